// File: doc/BRIEF.md
# Burst column address generator

This block turns one accepted start request into the run of column addresses that a memory burst visits, one address per data beat. The caller presents a starting column, a burst-length code and an ordering bit on a start strobe. The block then issues two, four or eight consecutive beats. Each beat carries its column address, and the final beat is marked. Read and write bursts use the same generator and the same programmed length.

The address never walks out of an aligned block whose size equals the burst length. Only the low one, two or three column bits move. They either count upward modulo the burst length (sequential order) or are formed as the starting offset XOR the beat number (interleaved order). A new start presented on the final beat chains directly into the next burst with no idle cycle between them. An unsupported length code is refused and reported with a one-cycle error pulse.

Top module: `colburst_gen`

## Requirements
- R1: During and directly after reset, `beatValid`, `lastBeat` and `modeErr` are 0 and `colAddr` is all zeros.
- R2: A strobe is accepted when no burst is running or on the final beat of a running burst. Length code 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. The first beat appears in the cycle after the accepting edge, and one beat follows per cycle with `beatValid` high.
- R3: The column address of beat 0 equals `startCol` as sampled at the accepting edge, for both orderings.
- R4: With `burstType` 0 (sequential), the low log2(BL) address bits of beat i equal (s + i) mod BL, where s is the starting low bits.
- R5: With `burstType` 1 (interleaved), the low log2(BL) address bits of beat i equal s XOR i.
- R6: Address bits at and above position log2(BL) keep the value they had in `startCol` on every beat of the burst.
- R7: `lastBeat` is high on beat BL-1 and on no other cycle.
- R8: A strobe accepted on the final beat starts the next burst in the following cycle, with `beatValid` staying high.
- R9: A strobe during a beat other than the last is ignored. The running burst continues with its own start, length and order, and no error is raised. Input changes between accepted strobes also have no effect.
- R10: An accepted strobe carrying a length code other than 001, 010 or 011 starts no burst. `modeErr` goes high for exactly the next cycle.
- R11: `colAddr` reads all zeros in every cycle where `beatValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| startStb | input | 1 | Request to start a burst |
| startCol | input | COL_W | Starting column address |
| lenCode | input | 3 | Burst length code (001=2, 010=4, 011=8) |
| burstType | input | 1 | Ordering: 0 sequential, 1 interleaved |
| beatValid | output | 1 | A burst beat is present this cycle |
| colAddr | output | COL_W | Column address of the current beat |
| lastBeat | output | 1 | Current beat is the final one of the burst |
| modeErr | output | 1 | Previous accepted strobe had a reserved length code |

## Verification
The bench builds the generator with a six-bit column. Random starting columns therefore regularly land on the top aligned block and on all-ones addresses, which exercises wrapping at the edge of the column space without a long run. The bench compares against a behavioural model every cycle. The stimulus covers exhaustive start offsets for every length and ordering, strobes held high across whole bursts so that chaining and ignored requests both occur, and every reserved code, both from idle and on a final beat.

// File: rtl/colburst_pkg.sv
package colburst_pkg;

  // Width of the in-block offset: the largest burst is eight beats.
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011
  } len_code_e;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] mask;   // burst length minus one
  } len_info_t;

  // Strobes and state handed from control to datapath.
  typedef struct packed {
    logic             active;
    logic             load;
    logic [IDX_W-1:0] loadMask;
    logic [IDX_W-1:0] beatIdx;
  } colburst_ctl_t;

  function automatic len_info_t decodeLen(input logic [2:0] code);
    len_info_t info;
    info.ok   = 1'b1;
    info.mask = '0;
    case (code)
      LEN_TWO:   info.mask = 3'd1;
      LEN_FOUR:  info.mask = 3'd3;
      LEN_EIGHT: info.mask = 3'd7;
      default:   info.ok   = 1'b0;
    endcase
    return info;
  endfunction

endpackage

// File: rtl/colburst_ctrl.sv
module colburst_ctrl
  import colburst_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          startStb,
  input  logic [2:0]    lenCode,
  output colburst_ctl_t ctl,
  output logic          beatValid,
  output logic          lastBeat,
  output logic          modeErr
);

  logic             activeQ;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] maskQ;
  logic             errQ;
  len_info_t        lenInfo;
  logic             accept;

  always_comb begin
    lenInfo  = decodeLen(lenCode);
    lastBeat = activeQ && (idxQ == maskQ);
    accept   = startStb && (!activeQ || lastBeat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
      idxQ    <= '0;
      maskQ   <= '0;
      errQ    <= 1'b0;
    end else begin
      errQ <= accept && !lenInfo.ok;
      if (accept) begin
        activeQ <= lenInfo.ok;
        idxQ    <= '0;
        if (lenInfo.ok) maskQ <= lenInfo.mask;
      end else if (activeQ) begin
        if (lastBeat) activeQ <= 1'b0;
        else          idxQ    <= idxQ + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.active   = activeQ;
    ctl.load     = accept && lenInfo.ok;
    ctl.loadMask = lenInfo.mask;
    ctl.beatIdx  = idxQ;
  end

  assign beatValid = activeQ;
  assign modeErr   = errQ;

endmodule

// File: rtl/colburst_path.sv
module colburst_path
  import colburst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  colburst_ctl_t ctl,
  input  logic [COL_W-1:0] startCol,
  input  logic          burstType,
  output logic [COL_W-1:0] colAddr
);

  logic [COL_W-1:0] startQ;
  logic             typeQ;
  logic [IDX_W-1:0] maskQ;
  logic [IDX_W-1:0] lowStart;
  logic [IDX_W-1:0] seqLow;
  logic [IDX_W-1:0] ilvLow;
  logic [IDX_W-1:0] pickLow;
  logic [IDX_W-1:0] mergedLow;
  logic [COL_W-1:0] beatAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startQ <= '0;
      typeQ  <= 1'b0;
      maskQ  <= '0;
    end else if (ctl.load) begin
      startQ <= startCol;
      typeQ  <= burstType;
      maskQ  <= ctl.loadMask;
    end
  end

  always_comb begin
    lowStart  = startQ[IDX_W-1:0] & maskQ;
    seqLow    = (lowStart + ctl.beatIdx) & maskQ;
    ilvLow    = (lowStart ^ ctl.beatIdx) & maskQ;
    pickLow   = typeQ ? ilvLow : seqLow;
    mergedLow = (startQ[IDX_W-1:0] & ~maskQ) | pickLow;
  end

  // Bits above the largest burst block pass straight through when present.
  if (COL_W > IDX_W) begin : g_upper
    assign beatAddr = {startQ[COL_W-1:IDX_W], mergedLow};
  end else begin : g_noupper
    assign beatAddr = mergedLow;
  end

  assign colAddr = ctl.active ? beatAddr : '0;

endmodule

// File: rtl/colburst_gen.sv
module colburst_gen
  import colburst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             burstType,
  output logic             beatValid,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat,
  output logic             modeErr
);

  colburst_ctl_t ctl;

  colburst_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startStb (startStb),
    .lenCode  (lenCode),
    .ctl      (ctl),
    .beatValid(beatValid),
    .lastBeat (lastBeat),
    .modeErr  (modeErr)
  );

  colburst_path #(.COL_W(COL_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .startCol (startCol),
    .burstType(burstType),
    .colAddr  (colAddr)
  );

endmodule

// File: rtl/colburst_chk.sv
module colburst_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic [2:0]       lenCode,
  input logic             beatValid,
  input logic [COL_W-1:0] colAddr,
  input logic             lastBeat,
  input logic             modeErr
);

  logic takeReq;
  logic codeOk;
  assign takeReq = startStb && (!beatValid || lastBeat);
  assign codeOk  = (lenCode == 3'b001) || (lenCode == 3'b010) || (lenCode == 3'b011);

  p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |-> beatValid);

  p_no_gap_mid_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && !lastBeat) |=> beatValid);

  p_stop_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lastBeat && !startStb) |=> !beatValid);

  p_chain_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lastBeat && startStb && codeOk) |=> beatValid);

  p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (takeReq && codeOk) |=> (colAddr == $past(startCol)));

  p_bad_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (takeReq && !codeOk) |=> (modeErr && !beatValid));

  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    modeErr |-> $past(startStb));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !beatValid |-> (colAddr == '0));

  if (COL_W > 3) begin : g_up
    p_upper_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (beatValid && !lastBeat) |=> $stable(colAddr[COL_W-1:3]));
  end

endmodule

bind colburst_gen colburst_chk #(.COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .startStb (startStb),
  .startCol (startCol),
  .lenCode  (lenCode),
  .beatValid(beatValid),
  .colAddr  (colAddr),
  .lastBeat (lastBeat),
  .modeErr  (modeErr)
);

// File: tb/tb_colburst_gen.sv
`timescale 1ns/1ps
module tb_colburst_gen;

  localparam int COL_W = 6;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startStb = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = 3'b001;
  logic             burstType = 1'b0;
  logic             beatValid;
  logic [COL_W-1:0] colAddr;
  logic             lastBeat;
  logic             modeErr;

  always #4 clk = ~clk;

  colburst_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .startCol(startCol),
    .lenCode(lenCode), .burstType(burstType), .beatValid(beatValid),
    .colAddr(colAddr), .lastBeat(lastBeat), .modeErr(modeErr)
  );

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 0;

  // Behavioural reference state
  int    mActive = 0, mIdx = 0, mBl = 2, mStart = 0, mType = 0, mErr = 0;
  string validTag = "R2";

  function automatic int blOf(input int code);
    if (code == 1) return 2;
    if (code == 2) return 4;
    if (code == 3) return 8;
    return 0;
  endfunction

  function automatic int refAddr();
    int lowS, low;
    lowS = mStart % mBl;
    if (mType != 0) low = lowS ^ mIdx;
    else            low = (lowS + mIdx) % mBl;
    return mStart - lowS + low;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mActive = 0; mIdx = 0; mErr = 0; validTag = "R2";
    end else begin
      bit acc;
      acc = startStb && (mActive == 0 || mIdx == mBl - 1);
      if (acc && mActive != 0) validTag = "R8";
      else if (startStb && !acc) validTag = "R9";
      else validTag = "R2";
      if (acc) begin
        if (blOf(int'(lenCode)) != 0) begin
          mActive = 1; mIdx = 0; mBl = blOf(int'(lenCode));
          mStart = int'(startCol); mType = int'(burstType); mErr = 0;
        end else begin
          mActive = 0; mIdx = 0; mErr = 1;
        end
      end else begin
        mErr = 0;
        if (mActive != 0) begin
          if (mIdx == mBl - 1) mActive = 0;
          else mIdx = mIdx + 1;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int expAddr;
      string aTag;
      expAddr = (mActive != 0) ? refAddr() : 0;
      check(validTag, "beatValid", int'(beatValid), mActive);
      check("R7", "lastBeat", int'(lastBeat), (mActive != 0 && mIdx == mBl - 1) ? 1 : 0);
      check("R10", "modeErr", int'(modeErr), mErr);
      if (mActive == 0) aTag = "R11";
      else if (mIdx == 0) aTag = "R3";
      else if (mType != 0) aTag = "R5";
      else aTag = "R4";
      check(aTag, "colAddr", int'(colAddr), expAddr);
      if (mActive != 0)
        check("R6", "upper bits", int'(colAddr) / mBl, mStart / mBl);
    end
  end

  task automatic drive(input bit stb, input int code, input bit typ, input int col);
    @(negedge clk);
    #1;
    startStb  = stb;
    lenCode   = 3'(code);
    burstType = typ;
    startCol  = COL_W'(col);
  endtask

  task automatic idleRandom(input int n);
    for (int k = 0; k < n; k++)
      drive(1'b0, int'($urandom % 8), 1'($urandom), int'($urandom % NCOL));
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errCnt++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check("R1", "reset beatValid", int'(beatValid), 0);
    check("R1", "reset lastBeat", int'(lastBeat), 0);
    check("R1", "reset modeErr", int'(modeErr), 0);
    check("R1", "reset colAddr", int'(colAddr), 0);
    @(negedge clk); #1 rst_n = 1'b1;

    // R2/R3/R4/R5/R6: every start offset for each length and order, isolated bursts
    for (int code = 1; code <= 3; code++)
      for (int typ = 0; typ < 2; typ++)
        for (int s = 0; s < 8; s++) begin
          drive(1'b1, code, 1'(typ), (s * 9 + 40) % NCOL);
          idleRandom(blOf(code) + 1);
        end

    // Top of column space
    drive(1'b1, 3, 1'b0, NCOL - 1); idleRandom(9);
    drive(1'b1, 3, 1'b1, NCOL - 3); idleRandom(9);

    // R8/R9: strobe held every cycle with valid codes
    for (int k = 0; k < 60; k++)
      drive(1'b1, 1 + int'($urandom % 3), 1'($urandom), int'($urandom % NCOL));
    idleRandom(9);

    // R10: each reserved code from idle
    for (int code = 0; code < 8; code++) begin
      if (blOf(code) == 0) begin
        drive(1'b1, code, 1'b0, 5);
        idleRandom(3);
      end
    end
    // R10 on the final beat of a running burst
    drive(1'b1, 2, 1'b0, 6); idleRandom(3);
    drive(1'b1, 7, 1'b1, 9); idleRandom(4);

    // Mixed random traffic
    for (int k = 0; k < 3000; k++)
      drive(($urandom % 3) == 0, int'($urandom % 8), 1'($urandom), int'($urandom % NCOL));
    idleRandom(10);

    finishRun();
  end

endmodule